// File: doc/BRIEF.md
# VGA Access Trap SMI Controller

This block sits beside a legacy VGA register file and turns selected accesses and display timing events into System Management Interrupts for firmware emulation. Each cycle it receives an already decoded register-group strobe with a direction bit, a pulse for an illegal CRTC index, two vertical-blank pulses, and the current output resolution of the VGA timing engine together with its enable and scaling flags.

A trapped register access raises `sync_smi_o` in the same cycle as the access, so the bus master can stall on it. Some sources also latch a sticky status flag. Blank and resolution events latch sticky flags that hold `async_smi_o` high until firmware clears them. A single 64-bit register gives access to the status flags, which are cleared by writing 1, and to the mask bits.

Top module: `vga_smi_trap`

## Requirements
- R1: After reset all register bits, `sync_smi_o` and `async_smi_o` are 0.
- R2: Group codes on `acc_grp_i` are 0 sequencer, 1 CRTC, 2 attribute, 3 graphics, 4 DAC, 5 misc output, 6 input status 0, 7 input status 1, and `acc_wr_i`=1 means write. On the clock edge of a valid access, the status bits are set as follows: sequencer read sets bit 40, sequencer write sets bit 39, CRTC read sets bit 38, CRTC write sets bit 37, input status 0 read sets bit 34, and misc output write sets bit 33. These six accesses cannot be masked.
- R3: `sync_smi_o` is high in exactly the cycle in which a trapped access or an illegal CRTC pulse is present, and is low in every other cycle.
- R4: Reads of input status 1, misc output, DAC, attribute and graphics, and writes to DAC and attribute, raise `sync_smi_o` without setting any status bit. Each of these is suppressed by its mask bit: 16 input status 1 read, 15 misc read, 14 DAC read, 13 DAC write, 12 attribute read, 11 attribute write, 10 graphics read.
- R5: A register write clears each status bit whose write-data bit is 1 and leaves unchanged each status bit whose write-data bit is 0. The same write loads mask bits 28 and 16:10 from the write data.
- R6: If a new event and a clear hit the same status bit in the same cycle, the bit remains set.
- R7: A VGA blank pulse sets bit 35 and a display-controller blank pulse sets bit 32. `async_smi_o` is high while bit 35, bit 32 or bit 41 is set, and it falls in the cycle after the last of these bits is cleared.
- R8: Bit 41 is set when the timing engine is enabled, scaling is enabled, and the horizontal or vertical resolution differs from its value in the previous cycle. No change is reported in the first cycle after the timing engine becomes enabled.
- R9: While mask bit 28 is 1, a resolution change does not set bit 41.
- R10: Bits 63:42, 31:29, 27:17 and 9:0 always read as 0, and writes to them have no effect.
- R11: An illegal CRTC pulse sets bit 36 and raises `sync_smi_o`, whatever the mask bits hold.
- R12: Graphics writes, input status 0 writes and input status 1 writes have no effect on the outputs or on any register bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_vld_i | input | 1 | A decoded register access is present |
| acc_grp_i | input | 3 | Register group code |
| acc_wr_i | input | 1 | 1 for a write, 0 for a read |
| crtc_bad_i | input | 1 | Pulse for an illegal CRTC register access |
| vga_vblank_i | input | 1 | Vertical blank pulse from the VGA timing engine |
| dc_vblank_i | input | 1 | Vertical blank pulse from the display controller |
| tg_en_i | input | 1 | VGA timing engine enabled |
| scale_en_i | input | 1 | Scaling enabled |
| hres_i | input | RES_W | Current horizontal resolution |
| vres_i | input | RES_W | Current vertical resolution |
| reg_wr_i | input | 1 | Write to the control register |
| reg_wdata_i | input | 64 | Write data |
| reg_rdata_o | output | 64 | Register read value |
| sync_smi_o | output | 1 | SMI for a trapped access, in the same cycle as the access |
| async_smi_o | output | 1 | Level SMI for blank and resolution events |

## Verification
The assertions assume that the group, direction and valid inputs are stable and free of X in every sampled cycle. They also assume that the resolution inputs change only on clock edges, so comparing them against the previous cycle is meaningful. The bench meets both conditions by driving every input from the falling edge. Its random mix keeps blank and illegal-index pulses rare and makes resolution steps sparse, so each flag is both set and cleared many times.

// File: rtl/vga_smi_pkg.sv
package vga_smi_pkg;
  localparam int GRP_W       = 3;
  localparam int REG_W       = 64;
  localparam int NSTAT       = 10;
  localparam int STAT_LSB    = 32;
  localparam int NMSK        = 7;
  localparam int MSK_LSB     = 10;
  localparam int RES_MSK_BIT = 28;

  typedef enum logic [GRP_W-1:0] {
    GRP_SEQ  = 3'd0,
    GRP_CRTC = 3'd1,
    GRP_ATTR = 3'd2,
    GRP_GFX  = 3'd3,
    GRP_DAC  = 3'd4,
    GRP_MISC = 3'd5,
    GRP_IS0  = 3'd6,
    GRP_IS1  = 3'd7
  } grp_e;

  // status index = register bit - STAT_LSB
  localparam int ST_DC_VB    = 0;
  localparam int ST_MISC_WR  = 1;
  localparam int ST_IS0_RD   = 2;
  localparam int ST_VGA_VB   = 3;
  localparam int ST_CRTC_BAD = 4;
  localparam int ST_CRTC_WR  = 5;
  localparam int ST_CRTC_RD  = 6;
  localparam int ST_SEQ_WR   = 7;
  localparam int ST_SEQ_RD   = 8;
  localparam int ST_RES_CHG  = 9;

  // mask index = register bit - MSK_LSB
  localparam int MK_GFX_RD  = 0;
  localparam int MK_ATTR_WR = 1;
  localparam int MK_ATTR_RD = 2;
  localparam int MK_DAC_WR  = 3;
  localparam int MK_DAC_RD  = 4;
  localparam int MK_MISC_RD = 5;
  localparam int MK_IS1_RD  = 6;
endpackage

// File: rtl/vga_smi_classify.sv
module vga_smi_classify
  import vga_smi_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_vld_i,
  input  logic [GRP_W-1:0] acc_grp_i,
  input  logic             acc_wr_i,
  input  logic             crtc_bad_i,
  input  logic [NMSK-1:0]  msk_i,
  output logic [NSTAT-1:0] set_o,
  output logic             sync_o
);
  grp_e grp;
  logic trap_only;

  assign grp = grp_e'(acc_grp_i);

  always_comb begin
    set_o     = '0;
    trap_only = 1'b0;
    if (acc_vld_i) begin
      case (grp)
        GRP_SEQ: begin
          if (acc_wr_i) set_o[ST_SEQ_WR] = 1'b1;
          else          set_o[ST_SEQ_RD] = 1'b1;
        end
        GRP_CRTC: begin
          if (acc_wr_i) set_o[ST_CRTC_WR] = 1'b1;
          else          set_o[ST_CRTC_RD] = 1'b1;
        end
        GRP_ATTR: trap_only = acc_wr_i ? !msk_i[MK_ATTR_WR] : !msk_i[MK_ATTR_RD];
        GRP_DAC:  trap_only = acc_wr_i ? !msk_i[MK_DAC_WR]  : !msk_i[MK_DAC_RD];
        GRP_GFX:  trap_only = !acc_wr_i && !msk_i[MK_GFX_RD];
        GRP_MISC: begin
          if (acc_wr_i) set_o[ST_MISC_WR] = 1'b1;
          else          trap_only = !msk_i[MK_MISC_RD];
        end
        GRP_IS0: begin
          if (!acc_wr_i) set_o[ST_IS0_RD] = 1'b1;
        end
        GRP_IS1:  trap_only = !acc_wr_i && !msk_i[MK_IS1_RD];
        default:  trap_only = 1'b0;
      endcase
    end
    set_o[ST_CRTC_BAD] = crtc_bad_i;
  end

  assign sync_o = trap_only || (|set_o);

  assert_dac_rd_masked_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_vld_i && grp == GRP_DAC && !acc_wr_i && msk_i[MK_DAC_RD] && !crtc_bad_i) |-> !sync_o);

  assert_gfx_wr_ignored_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_vld_i && grp == GRP_GFX && acc_wr_i && !crtc_bad_i) |-> (!sync_o && set_o == '0));
endmodule

// File: rtl/vga_smi_res_det.sv
module vga_smi_res_det #(
  parameter int RES_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tg_en_i,
  input  logic             scale_en_i,
  input  logic [RES_W-1:0] hres_i,
  input  logic [RES_W-1:0] vres_i,
  output logic             chg_o
);
  logic             en_q;
  logic [RES_W-1:0] h_q, v_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0;
      h_q  <= '0;
      v_q  <= '0;
    end else begin
      en_q <= tg_en_i;
      h_q  <= hres_i;
      v_q  <= vres_i;
    end
  end

  // en_q gates out the first enabled cycle
  assign chg_o = tg_en_i && scale_en_i && en_q && ((hres_i != h_q) || (vres_i != v_q));

  assert_no_chg_on_enable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tg_en_i) |-> !chg_o);

  assert_chg_needs_move_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_o |-> (!$stable(hres_i) || !$stable(vres_i)));
endmodule

// File: rtl/vga_smi_regs.sv
module vga_smi_regs
  import vga_smi_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NSTAT-1:0] set_i,
  input  logic             reg_wr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [NSTAT-1:0] status_o,
  output logic [NMSK-1:0]  msk_o,
  output logic             res_msk_o,
  output logic [REG_W-1:0] rdata_o
);
  logic [NSTAT-1:0] clr;
  logic [NMSK-1:0]  msk_q;
  logic             res_msk_q;

  assign clr = reg_wr_i ? reg_wdata_i[STAT_LSB +: NSTAT] : '0;

  for (genvar i = 0; i < NSTAT; i++) begin : g_stat
    logic bit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       bit_q <= 1'b0;
      else if (set_i[i]) bit_q <= 1'b1;  // event beats clear
      else if (clr[i])   bit_q <= 1'b0;
    end
    assign status_o[i] = bit_q;

    assert_w1c_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reg_wr_i && reg_wdata_i[STAT_LSB+i] && !set_i[i]) |=> !status_o[i]);
    assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (status_o[i] && !(reg_wr_i && reg_wdata_i[STAT_LSB+i])) |=> status_o[i]);
    assert_set_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> status_o[i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msk_q     <= '0;
      res_msk_q <= 1'b0;
    end else if (reg_wr_i) begin
      msk_q     <= reg_wdata_i[MSK_LSB +: NMSK];
      res_msk_q <= reg_wdata_i[RES_MSK_BIT];
    end
  end

  assign msk_o     = msk_q;
  assign res_msk_o = res_msk_q;

  always_comb begin
    rdata_o                     = '0;
    rdata_o[STAT_LSB +: NSTAT]  = status_o;
    rdata_o[MSK_LSB +: NMSK]    = msk_q;
    rdata_o[RES_MSK_BIT]        = res_msk_q;
  end

  logic unused_wdata;
  assign unused_wdata = ^{reg_wdata_i[REG_W-1:STAT_LSB+NSTAT],
                          reg_wdata_i[STAT_LSB-1:RES_MSK_BIT+1],
                          reg_wdata_i[RES_MSK_BIT-1:MSK_LSB+NMSK],
                          reg_wdata_i[MSK_LSB-1:0]};
endmodule

// File: rtl/vga_smi_trap.sv
module vga_smi_trap
  import vga_smi_pkg::*;
#(
  parameter int RES_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_vld_i,
  input  logic [2:0]       acc_grp_i,
  input  logic             acc_wr_i,
  input  logic             crtc_bad_i,
  input  logic             vga_vblank_i,
  input  logic             dc_vblank_i,
  input  logic             tg_en_i,
  input  logic             scale_en_i,
  input  logic [RES_W-1:0] hres_i,
  input  logic [RES_W-1:0] vres_i,
  input  logic             reg_wr_i,
  input  logic [63:0]      reg_wdata_i,
  output logic [63:0]      reg_rdata_o,
  output logic             sync_smi_o,
  output logic             async_smi_o
);
  logic [NSTAT-1:0] acc_set, set_all, status;
  logic [NMSK-1:0]  msk;
  logic             res_msk, res_chg;

  vga_smi_classify u_cls (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .acc_vld_i  (acc_vld_i),
    .acc_grp_i  (acc_grp_i),
    .acc_wr_i   (acc_wr_i),
    .crtc_bad_i (crtc_bad_i),
    .msk_i      (msk),
    .set_o      (acc_set),
    .sync_o     (sync_smi_o)
  );

  vga_smi_res_det #(.RES_W(RES_W)) u_res (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tg_en_i    (tg_en_i),
    .scale_en_i (scale_en_i),
    .hres_i     (hres_i),
    .vres_i     (vres_i),
    .chg_o      (res_chg)
  );

  always_comb begin
    set_all             = acc_set;
    set_all[ST_VGA_VB]  = vga_vblank_i;
    set_all[ST_DC_VB]   = dc_vblank_i;
    set_all[ST_RES_CHG] = res_chg && !res_msk;
  end

  vga_smi_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_i       (set_all),
    .reg_wr_i    (reg_wr_i),
    .reg_wdata_i (reg_wdata_i),
    .status_o    (status),
    .msk_o       (msk),
    .res_msk_o   (res_msk),
    .rdata_o     (reg_rdata_o)
  );

  assign async_smi_o = status[ST_VGA_VB] || status[ST_DC_VB] || status[ST_RES_CHG];

  assert_sync_has_source_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_smi_o |-> (acc_vld_i || crtc_bad_i));

  assert_async_drop_on_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(async_smi_o) |-> $past(reg_wr_i));

  assert_res_mask_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_msk && !status[ST_RES_CHG]) |=> !status[ST_RES_CHG]);

  assert_bad_crtc_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crtc_bad_i |-> (sync_smi_o && set_all[ST_CRTC_BAD]));
endmodule

// File: tb/vga_smi_trap_tb_top.sv
`timescale 1ns/1ps
module vga_smi_trap_tb_top;
  localparam int RES_W = 12;
  localparam int N_RAND = 4000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_vld, acc_wr, crtc_bad, vga_vb, dc_vb, tg_en, scale_en, reg_wr;
  logic [2:0] acc_grp;
  logic [RES_W-1:0] hres, vres;
  logic [63:0] reg_wdata, rdata;
  logic sync_smi, async_smi;

  logic [9:0] m_st;
  logic [6:0] m_msk;
  logic m_rmsk, p_en;
  logic [RES_W-1:0] p_h, p_v;
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  vga_smi_trap #(.RES_W(RES_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .acc_vld_i(acc_vld), .acc_grp_i(acc_grp),
    .acc_wr_i(acc_wr), .crtc_bad_i(crtc_bad), .vga_vblank_i(vga_vb),
    .dc_vblank_i(dc_vb), .tg_en_i(tg_en), .scale_en_i(scale_en),
    .hres_i(hres), .vres_i(vres), .reg_wr_i(reg_wr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(rdata), .sync_smi_o(sync_smi), .async_smi_o(async_smi)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic exp_sync();
    logic t = 1'b0;
    if (acc_vld) begin
      case (acc_grp)
        3'd0, 3'd1: t = 1'b1;
        3'd2: t = acc_wr ? !m_msk[1] : !m_msk[2];
        3'd3: t = !acc_wr && !m_msk[0];
        3'd4: t = acc_wr ? !m_msk[3] : !m_msk[4];
        3'd5: t = acc_wr ? 1'b1 : !m_msk[5];
        3'd6: t = !acc_wr;
        default: t = !acc_wr && !m_msk[6];
      endcase
    end
    return t || crtc_bad;
  endfunction

  // bits relative to register bit 32
  function automatic logic [9:0] exp_set();
    logic [9:0] s = '0;
    if (acc_vld) begin
      if (acc_grp == 3'd0) s[acc_wr ? 7 : 8] = 1'b1;
      if (acc_grp == 3'd1) s[acc_wr ? 5 : 6] = 1'b1;
      if (acc_grp == 3'd5 && acc_wr) s[1] = 1'b1;
      if (acc_grp == 3'd6 && !acc_wr) s[2] = 1'b1;
    end
    s[4] = crtc_bad;
    s[3] = vga_vb;
    s[0] = dc_vb;
    s[9] = tg_en && scale_en && p_en && (hres != p_h || vres != p_v) && !m_rmsk;
    return s;
  endfunction

  function automatic logic [63:0] pack();
    logic [63:0] r = '0;
    r[41:32] = m_st;
    r[28]    = m_rmsk;
    r[16:10] = m_msk;
    return r;
  endfunction

  task automatic idle();
    acc_vld = 0; acc_wr = 0; acc_grp = 0; crtc_bad = 0; vga_vb = 0; dc_vb = 0;
    reg_wr = 0; reg_wdata = '0;
  endtask

  task automatic step();
    logic [9:0] s;
    #1;
    check(sync_smi === exp_sync(), "R3 sync", {63'd0, sync_smi}, {63'd0, exp_sync()});
    check(rdata === pack(), "R2 rdata", rdata, pack());
    check(async_smi === (m_st[3] | m_st[0] | m_st[9]), "R7 async",
          {63'd0, async_smi}, {63'd0, (m_st[3] | m_st[0] | m_st[9])});
    s = exp_set();
    @(posedge clk);
    m_st = (m_st & ~(reg_wr ? reg_wdata[41:32] : 10'd0)) | s;
    if (reg_wr) begin
      m_msk  = reg_wdata[16:10];
      m_rmsk = reg_wdata[28];
    end
    p_en = tg_en; p_h = hres; p_v = vres;
    @(negedge clk);
  endtask

  task automatic wreg(input logic [63:0] d);
    idle(); reg_wr = 1; reg_wdata = d; step(); idle();
  endtask

  task automatic acc(input logic [2:0] g, input logic w);
    idle(); acc_vld = 1; acc_grp = g; acc_wr = w;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual %h expected %h", 64'd0, 64'd1);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    idle(); tg_en = 0; scale_en = 0; hres = 12'd640; vres = 12'd480;
    m_st = '0; m_msk = '0; m_rmsk = 0; p_en = 0; p_h = '0; p_v = '0;
    repeat (3) @(negedge clk);
    #1;
    check(rdata === 64'd0, "R1 rdata", rdata, 64'd0);
    check(sync_smi === 1'b0 && async_smi === 1'b0, "R1 outs", {62'd0, sync_smi, async_smi}, 64'd0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R2 status positions
    acc(3'd0, 0); step(); check(rdata[40] === 1'b1, "R2 seq rd", rdata, 64'd1 << 40);
    acc(3'd0, 1); step(); check(rdata[39] === 1'b1, "R2 seq wr", rdata, 64'd1 << 39);
    acc(3'd1, 0); step(); check(rdata[38] === 1'b1, "R2 crtc rd", rdata, 64'd1 << 38);
    acc(3'd1, 1); step(); check(rdata[37] === 1'b1, "R2 crtc wr", rdata, 64'd1 << 37);
    acc(3'd6, 0); step(); check(rdata[34] === 1'b1, "R2 is0 rd", rdata, 64'd1 << 34);
    acc(3'd5, 1); step(); check(rdata[33] === 1'b1, "R2 misc wr", rdata, 64'd1 << 33);
    wreg(64'h3FF << 32);
    check(rdata === 64'd0, "R5 clear all", rdata, 64'd0);

    // R3 one-cycle trap
    acc(3'd2, 1); #1 check(sync_smi === 1'b1, "R3 attr wr", {63'd0, sync_smi}, 64'd1);
    step(); idle(); #1 check(sync_smi === 1'b0, "R3 drop", {63'd0, sync_smi}, 64'd0);
    check(rdata === 64'd0, "R4 no status", rdata, 64'd0);

    // R4 masking
    wreg(64'd1 << 14);
    acc(3'd4, 0); #1 check(sync_smi === 1'b0, "R4 dac rd masked", {63'd0, sync_smi}, 64'd0);
    step();
    acc(3'd4, 1); #1 check(sync_smi === 1'b1, "R4 dac wr open", {63'd0, sync_smi}, 64'd1);
    step();
    wreg(64'd0);

    // R5 selective clear
    acc(3'd0, 0); step(); acc(3'd1, 0); step(); idle();
    wreg(64'd1 << 40);
    check(rdata[40] === 1'b0 && rdata[38] === 1'b1, "R5 selective", rdata, 64'd1 << 38);

    // R6 set beats clear
    acc(3'd1, 0); reg_wr = 1; reg_wdata = 64'd1 << 38; step(); idle();
    check(rdata[38] === 1'b1, "R6 collide", rdata, 64'd1 << 38);
    wreg(64'h3FF << 32);

    // R7 blank levels
    vga_vb = 1; step(); idle(); step();
    check(async_smi === 1'b1 && rdata[35] === 1'b1, "R7 vga set", rdata, 64'd1 << 35);
    dc_vb = 1; step(); idle();
    wreg(64'd1 << 35);
    check(async_smi === 1'b1, "R7 dc holds", {63'd0, async_smi}, 64'd1);
    wreg(64'd1 << 32);
    check(async_smi === 1'b0, "R7 dropped", {63'd0, async_smi}, 64'd0);

    // R8 resolution change
    scale_en = 1; tg_en = 0; step(); step();
    tg_en = 1; hres = 12'd800; step();
    check(rdata[41] === 1'b0, "R8 first cycle", rdata, 64'd0);
    hres = 12'd1024; step();
    check(rdata[41] === 1'b1 && async_smi === 1'b1, "R8 change", rdata, 64'd1 << 41);
    wreg(64'd1 << 41);
    scale_en = 0; vres = 12'd600; step(); scale_en = 1; step();
    check(rdata[41] === 1'b0, "R8 no scale", rdata, 64'd0);

    // R9 resolution mask
    wreg(64'd1 << 28);
    vres = 12'd768; step();
    check(rdata[41] === 1'b0 && async_smi === 1'b0, "R9 masked", rdata, 64'd1 << 28);
    tg_en = 0;

    // R10 reserved bits
    wreg('1);
    check(rdata === 64'h0000_0000_1001_FC00, "R10 reserved", rdata, 64'h0000_0000_1001_FC00);

    // R11 illegal CRTC under full mask
    idle(); crtc_bad = 1; #1 check(sync_smi === 1'b1, "R11 sync", {63'd0, sync_smi}, 64'd1);
    step(); idle();
    check(rdata[36] === 1'b1, "R11 status", rdata, 64'd1 << 36);
    wreg(64'h3FF << 32);

    // R12 untrapped writes
    acc(3'd3, 1); #1 check(sync_smi === 1'b0, "R12 gfx wr", {63'd0, sync_smi}, 64'd0); step();
    acc(3'd6, 1); #1 check(sync_smi === 1'b0, "R12 is0 wr", {63'd0, sync_smi}, 64'd0); step();
    acc(3'd7, 1); #1 check(sync_smi === 1'b0, "R12 is1 wr", {63'd0, sync_smi}, 64'd0); step();
    idle();
    check(rdata[41:32] === 10'd0, "R12 no status", rdata, 64'd0);

    // random mix
    tg_en = 1; scale_en = 1;
    for (int i = 0; i < N_RAND; i++) begin
      acc_vld   = ($urandom % 2) == 0;
      acc_grp   = 3'($urandom % 8);
      acc_wr    = ($urandom % 2) == 0;
      crtc_bad  = ($urandom % 20) == 0;
      vga_vb    = ($urandom % 30) == 0;
      dc_vb     = ($urandom % 30) == 0;
      if (($urandom % 100) == 0) tg_en = ~tg_en;
      if (($urandom % 60) == 0) scale_en = ~scale_en;
      if (($urandom % 25) == 0) hres = RES_W'($urandom);
      if (($urandom % 25) == 0) vres = RES_W'($urandom);
      reg_wr    = ($urandom % 8) == 0;
      reg_wdata = {$urandom, $urandom};
      step();
    end
    idle(); step();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule